// File: doc/BRIEF.md
# I2C Odometer Counter Updater

This block keeps a 24-bit distance total in an external serial EEPROM and updates it once for every distance pulse. Each update is a read-modify-write over a two-wire bus. The block first polls the device until it answers. It then reads the three count bytes, adds one with carry across all three bytes, and writes the bytes back in a single page write. The block is the only master on the bus. It pulls SCL and SDA low through open-drain style outputs, and all bus timing comes from a quarter-bit divider derived from the clock and SCL rates.

The count is stored big-endian. Location 00h holds the most-significant byte, 01h the middle byte and 02h the least-significant byte. Pulses that arrive while an update is running are queued in a small saturating counter, and each queued pulse later produces one full update. Internally the sequencer hands bus operations to the bit engine over a valid/ready pair. A command is held until it is accepted, and the engine accepts nothing while a bit sequence is in progress. The pins at the block's edge are plain control and status lines.

Top module: `odo_i2c_ctrl`

## Requirements
- R1: After reset, busy and err are low and both bus lines are released (scl_drive_low = 0, sda_drive_low = 0).
- R2: Each rising edge of dist_pulse produces one update. Afterwards the bytes at 00h, 01h and 02h, read as a 24-bit big-endian number with the MSB at 00h, equal the old value plus one.
- R3: The increment carries from the byte at 02h through 01h into 00h. The value FFFFFFh wraps to 000000h.
- R4: The control byte is 1010 000 followed by the R/W bit, giving A0h for a write and A1h for a read. While the device answers the first control byte of an update with NACK, the block repeats Start and that control byte until it receives ACK.
- R5: The read phase is: Start, A0h, address 00h, repeated Start, A1h, then three data bytes. The master sends ACK after the first two data bytes and NACK after the third, then sends Stop.
- R6: The write phase is one transaction: Start, A0h, address 00h, the three new bytes in MSB-to-LSB order, then Stop.
- R7: Pulses that arrive during an update are queued, up to 2^PEND_W-1 of them, and each queued pulse runs one more update. Once the queue is full, further pulses are dropped.
- R8: A NACK on an address byte, on a later control byte or on a written data byte aborts the update. The block sends Stop, raises err and restarts from polling. err stays high until the next queued update is taken.
- R9: SDA driven by the master changes only while SCL is low, except for the Start and Stop edges. SCL stays high for at least two quarter periods, where one quarter period is CLK_HZ/(4*SCL_HZ) clocks. SCL_HZ is at most 400 kHz.
- R10: busy rises within a few cycles of a pulse and stays high until the final Stop. While busy is low, both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_pulse | input | 1 | Distance pulse; each rising edge requests one update |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | An update is in progress |
| err | output | 1 | The last update needed an abort and retry |

## Verification
The bench targets the carry boundaries 00FFFFh, 0000FFh and the FFFFFFh wrap. An incrementer that dropped a carry would store 00FF00h or 000000h-like garbage in place of the true next value. It fires a pulse immediately after a write so the device is still busy. A design that did not repeat the control byte would abort or read nothing, and the stored total would fall behind. It bursts pulses past the queue depth, where an undersized or wrapping queue shows up as a missing or extra increment. It also injects a NACK on the first written byte, where a design without the abort-and-retry path would hang or lose the update and leave err low. The bench further counts the read acknowledges and Stops. This catches a design that ACKs the last read byte or splits the page write.

// File: rtl/odo_pkg.sv
package odo_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE} bus_op_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_P_START, ST_P_CTRL, ST_R_ADDR, ST_R_RSTART, ST_R_CTRL,
    ST_R_D0, ST_R_D1, ST_R_D2, ST_R_STOP, ST_W_START, ST_W_CTRL,
    ST_W_ADDR, ST_W_D0, ST_W_D1, ST_W_D2, ST_W_STOP, ST_ABORT
  } seq_st_e;

  localparam logic [7:0] CTRL_WR = 8'hA0;
  localparam logic [7:0] CTRL_RD = 8'hA1;
  localparam logic [7:0] CNT_ADDR = 8'h00;
endpackage

// File: rtl/odo_pend.sv
module odo_pend #(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add,
  input  logic              take,
  output logic              nz,
  output logic [PEND_W-1:0] cnt
);
  localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

  logic inc;
  assign inc = add && (cnt != MAXV);
  assign nz  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !take) cnt <= cnt + 1'b1;
    else if (!inc && take) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/odo_inc.sv
module odo_inc #(
  parameter int BYTES = 3
) (
  input  logic [8*BYTES-1:0] val_i,
  output logic [8*BYTES-1:0] val_o
);
  logic [BYTES:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign val_o[8*g +: 8] = val_i[8*g +: 8] + {7'd0, carry[g]};
    assign carry[g+1]      = carry[g] & (&val_i[8*g +: 8]);
  end
endmodule

// File: rtl/odo_bit_engine.sv
module odo_bit_engine
  import odo_pkg::*;
#(
  parameter int QTR = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  bus_op_e    cmd_op,
  input  logic [8:0] cmd_bits,
  input  logic       sda_in,
  output logic       done,
  output logic [8:0] rx_bits,
  output logic       scl_low,
  output logic       sda_low,
  output logic       cond_fire
);
  localparam int DW = $clog2(QTR + 1);

  logic          busy_q;
  bus_op_e       op_q;
  logic [1:0]    ph_q;
  logic [3:0]    nbit_q;
  logic [8:0]    sh_q;
  logic [DW-1:0] div_q;
  logic          tick;
  logic          last_q;

  assign tick      = busy_q && (div_q == DW'(QTR - 1));
  assign cmd_ready = !busy_q;
  assign cond_fire = tick && (ph_q == 2'd3) && (op_q != OP_BYTE);
  assign last_q    = (op_q != OP_BYTE) || (nbit_q == 4'd8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= OP_START;
      ph_q    <= 2'd0;
      nbit_q  <= 4'd0;
      sh_q    <= '0;
      rx_bits <= '0;
      div_q   <= '0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_valid && !busy_q) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op;
        ph_q   <= 2'd0;
        nbit_q <= 4'd0;
        sh_q   <= cmd_bits;
        div_q  <= '0;
      end else if (busy_q) begin
        div_q <= tick ? '0 : div_q + 1'b1;
      end
      if (tick) begin
        ph_q <= ph_q + 2'd1;
        unique case (ph_q)
          2'd0: scl_low <= 1'b1;
          2'd1: begin
            if (op_q == OP_START)     sda_low <= 1'b0;
            else if (op_q == OP_STOP) sda_low <= 1'b1;
            else                      sda_low <= ~sh_q[8];
          end
          2'd2: scl_low <= 1'b0;
          default: begin
            if (op_q == OP_START)     sda_low <= 1'b1;
            else if (op_q == OP_STOP) sda_low <= 1'b0;
            else begin
              rx_bits <= {rx_bits[7:0], sda_in};
              sh_q    <= {sh_q[7:0], 1'b1};
              nbit_q  <= nbit_q + 4'd1;
            end
            if (last_q) begin
              busy_q <= 1'b0;
              done   <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/odo_seq.sv
module odo_seq
  import odo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pend_nz,
  output logic        take,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output bus_op_e     cmd_op,
  output logic [8:0]  cmd_bits,
  input  logic        done,
  input  logic [8:0]  rx_bits,
  output logic [23:0] cnt_cur,
  input  logic [23:0] cnt_inc,
  output logic        busy,
  output logic        err
);
  seq_st_e st_q;
  logic    issued_q;
  logic    ack;

  assign ack       = ~rx_bits[0];
  assign busy      = (st_q != ST_IDLE);
  assign take      = (st_q == ST_IDLE) && pend_nz;
  assign cmd_valid = busy && !issued_q;

  always_comb begin
    cmd_op   = OP_BYTE;
    cmd_bits = {8'hFF, 1'b1};
    unique case (st_q)
      ST_P_START, ST_R_RSTART, ST_W_START: cmd_op = OP_START;
      ST_R_STOP, ST_W_STOP, ST_ABORT:      cmd_op = OP_STOP;
      ST_P_CTRL, ST_W_CTRL:                cmd_bits = {CTRL_WR, 1'b1};
      ST_R_CTRL:                           cmd_bits = {CTRL_RD, 1'b1};
      ST_R_ADDR, ST_W_ADDR:                cmd_bits = {CNT_ADDR, 1'b1};
      ST_R_D0, ST_R_D1:                    cmd_bits = {8'hFF, 1'b0};
      ST_W_D0:                             cmd_bits = {cnt_cur[23:16], 1'b1};
      ST_W_D1:                             cmd_bits = {cnt_cur[15:8], 1'b1};
      ST_W_D2:                             cmd_bits = {cnt_cur[7:0], 1'b1};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      cnt_cur  <= '0;
      err      <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) issued_q <= 1'b1;
      if (take) begin
        st_q <= ST_P_START;
        err  <= 1'b0;
      end else if (done) begin
        issued_q <= 1'b0;
        unique case (st_q)
          ST_P_START:  st_q <= ST_P_CTRL;
          ST_P_CTRL:   st_q <= ack ? ST_R_ADDR : ST_P_START;
          ST_R_ADDR:   st_q <= ack ? ST_R_RSTART : ST_ABORT;
          ST_R_RSTART: st_q <= ST_R_CTRL;
          ST_R_CTRL:   st_q <= ack ? ST_R_D0 : ST_ABORT;
          ST_R_D0: begin cnt_cur[23:16] <= rx_bits[8:1]; st_q <= ST_R_D1; end
          ST_R_D1: begin cnt_cur[15:8]  <= rx_bits[8:1]; st_q <= ST_R_D2; end
          ST_R_D2: begin cnt_cur[7:0]   <= rx_bits[8:1]; st_q <= ST_R_STOP; end
          ST_R_STOP: begin cnt_cur <= cnt_inc; st_q <= ST_W_START; end
          ST_W_START:  st_q <= ST_W_CTRL;
          ST_W_CTRL:   st_q <= ack ? ST_W_ADDR : ST_ABORT;
          ST_W_ADDR:   st_q <= ack ? ST_W_D0 : ST_ABORT;
          ST_W_D0:     st_q <= ack ? ST_W_D1 : ST_ABORT;
          ST_W_D1:     st_q <= ack ? ST_W_D2 : ST_ABORT;
          ST_W_D2:     st_q <= ack ? ST_W_STOP : ST_ABORT;
          ST_W_STOP:   st_q <= ST_IDLE;
          ST_ABORT:    st_q <= ST_P_START;
          default:     st_q <= ST_IDLE;
        endcase
        if (!ack && (st_q inside {ST_R_ADDR, ST_R_CTRL, ST_W_CTRL, ST_W_ADDR,
                                  ST_W_D0, ST_W_D1, ST_W_D2}))
          err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/odo_i2c_ctrl.sv
module odo_i2c_ctrl #(
  parameter int CLK_HZ = 100_000_000,
  parameter int SCL_HZ = 400_000,
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dist_pulse,
  input  logic sda_in,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic busy,
  output logic err
);
  import odo_pkg::*;

  localparam int QTR_RAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QTR     = (QTR_RAW < 1) ? 1 : QTR_RAW;

  logic              pulse_q;
  logic              rise;
  logic              take;
  logic              pend_nz;
  logic [PEND_W-1:0] pend_cnt;
  logic              cmd_valid;
  logic              cmd_ready;
  bus_op_e           cmd_op;
  logic [8:0]        cmd_bits;
  logic              done;
  logic [8:0]        rx_bits;
  logic              cond_fire;
  logic [23:0]       cnt_cur;
  logic [23:0]       cnt_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= dist_pulse;
  end
  assign rise = dist_pulse & ~pulse_q;

  odo_pend #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .add(rise), .take(take),
    .nz(pend_nz), .cnt(pend_cnt)
  );

  odo_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .take(take),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bits(cmd_bits), .done(done), .rx_bits(rx_bits),
    .cnt_cur(cnt_cur), .cnt_inc(cnt_inc), .busy(busy), .err(err)
  );

  odo_inc #(.BYTES(3)) u_inc (.val_i(cnt_cur), .val_o(cnt_inc));

  odo_bit_engine #(.QTR(QTR)) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bits(cmd_bits), .sda_in(sda_in), .done(done),
    .rx_bits(rx_bits), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .cond_fire(cond_fire)
  );
endmodule

// File: rtl/odo_i2c_checker.sv
module odo_i2c_checker #(
  parameter int SCL_HZ = 400_000,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_low,
  input logic              sda_low,
  input logic              cond_fire,
  input logic              busy,
  input logic              err,
  input logic              take,
  input logic              rise,
  input logic              pend_nz,
  input logic [PEND_W-1:0] pend_cnt
);
  localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

  initial begin
    p_scl_rate_r9 : assert (SCL_HZ <= 400_000);
  end

  p_sda_edge_scl_high_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low))) |-> $past(cond_fire));

  p_idle_released_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  p_pending_starts_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pend_nz) |=> busy);

  p_pend_grow_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !take && pend_cnt != MAXV) |=> (pend_cnt == $past(pend_cnt) + 1'b1));

  p_pend_sat_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !take && pend_cnt == MAXV) |=> (pend_cnt == MAXV));

  p_err_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> $stable(err));
endmodule

bind odo_i2c_ctrl odo_i2c_checker #(.SCL_HZ(SCL_HZ), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
  .cond_fire(cond_fire), .busy(busy), .err(err), .take(take), .rise(rise),
  .pend_nz(pend_nz), .pend_cnt(pend_cnt)
);

// File: tb/tb_odo_i2c_ctrl.sv
module tb_odo_i2c_ctrl;
  localparam int BUSY_CYC = 300;
  localparam int QTR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_pulse = 1'b0;
  logic scl_drive_low, sda_drive_low, busy, err;
  logic s_low;
  wire  scl = ~scl_drive_low;
  wire  sda = ~(sda_drive_low | s_low);

  always #5 clk = ~clk;

  odo_i2c_ctrl #(.CLK_HZ(4_000_000), .SCL_HZ(400_000), .PEND_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .dist_pulse(dist_pulse), .sda_in(sda),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .err(err)
  );

  // ---------------- EEPROM slave model ----------------
  logic [7:0] mem [0:7];
  logic       scl_p, sda_p, first_rd, mack, inj;
  logic [7:0] sr, tx, addr_byte;
  logic [2:0] ptr;
  int bc, role, busy_t, wcnt;
  int n_stop, rd_ack, rd_nack, poll_nacks, n_a1, wr_cnt_last, wr_addr_last;
  logic clr_req = 1'b0, pre_req = 1'b0, inj_req = 1'b0;
  logic [23:0] pre_val = '0;

  always @(posedge clk) begin
    scl_p <= scl;
    sda_p <= sda;
    if (busy_t > 0) busy_t <= busy_t - 1;
    if (clr_req) begin
      n_stop <= 0; rd_ack <= 0; rd_nack <= 0; poll_nacks <= 0; n_a1 <= 0;
      wr_cnt_last <= -1; wr_addr_last <= -1;
    end
    if (pre_req) begin
      mem[0] <= pre_val[23:16]; mem[1] <= pre_val[15:8]; mem[2] <= pre_val[7:0];
    end
    if (inj_req) inj <= 1'b1;
    if (!rst_n) begin
      s_low <= 1'b0; bc <= 0; role <= 4; busy_t <= 0; wcnt <= 0; inj <= 1'b0;
      ptr <= '0; first_rd <= 1'b0; mack <= 1'b0;
    end else if (scl && scl_p && sda_p && !sda) begin
      bc <= 0; role <= 0; s_low <= 1'b0; wcnt <= 0;
    end else if (scl && scl_p && !sda_p && sda) begin
      n_stop <= n_stop + 1;
      if (wcnt > 0) begin
        busy_t <= BUSY_CYC; wr_cnt_last <= wcnt; wr_addr_last <= int'(addr_byte);
      end
      role <= 4; s_low <= 1'b0; wcnt <= 0;
    end else if (scl && !scl_p) begin
      if (bc < 8 && role != 3) sr <= {sr[6:0], sda};
      if (bc == 8 && role == 3) mack <= !sda;
      bc <= bc + 1;
    end else if (!scl && scl_p) begin
      if (bc == 8) begin
        case (role)
          0: if (sr[7:1] == 7'b1010000 && busy_t == 0) begin
               s_low <= 1'b1;
               if (sr[0]) begin role <= 3; first_rd <= 1'b1; n_a1 <= n_a1 + 1; end
               else role <= 1;
             end else begin
               s_low <= 1'b0; role <= 4;
               if (busy_t > 0) poll_nacks <= poll_nacks + 1;
             end
          1: begin ptr <= sr[2:0]; addr_byte <= sr; s_low <= 1'b1; role <= 2; end
          2: if (inj && wcnt == 0) begin
               inj <= 1'b0; s_low <= 1'b0; role <= 4;
             end else begin
               mem[ptr] <= sr; ptr <= ptr + 3'd1; wcnt <= wcnt + 1; s_low <= 1'b1;
             end
          default: s_low <= 1'b0;
        endcase
      end else if (bc == 9) begin
        bc <= 0; s_low <= 1'b0;
        if (role == 3) begin
          if (!first_rd) begin
            if (mack) rd_ack <= rd_ack + 1; else rd_nack <= rd_nack + 1;
          end
          if (first_rd || mack) begin
            tx <= mem[ptr]; s_low <= !mem[ptr][7]; ptr <= ptr + 3'd1; first_rd <= 1'b0;
          end else role <= 4;
        end
      end else if (role == 3 && bc >= 1 && bc <= 7) begin
        s_low <= !tx[7 - bc];
      end
    end
  end

  // ---------------- SCL high-time monitor ----------------
  int hi_run = 0, min_hi = 1000000;
  always @(posedge clk) begin
    if (scl) hi_run <= hi_run + 1;
    else begin
      if (hi_run > 0 && hi_run < min_hi) min_hi <= hi_run;
      hi_run <= 0;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  function automatic logic [23:0] exp_count(logic [23:0] v, int n);
    return v + 24'(n);
  endfunction

  function automatic logic [23:0] stored();
    return {mem[0], mem[1], mem[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic pulse();
    @(negedge clk); dist_pulse = 1'b1;
    @(negedge clk);
    @(negedge clk); dist_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 40) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic clear_stats();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic preset(input logic [23:0] v);
    @(negedge clk); pre_val = v; pre_req = 1'b1;
    @(negedge clk); pre_req = 1'b0;
  endtask

  task automatic carry_case(input logic [23:0] v);
    preset(v); pulse(); wait_idle();
    chk(stored() == exp_count(v, 1), "R3 carry/wrap", 32'(stored()), 32'(exp_count(v, 1)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(err == 1'b0, "R1 err", 32'(err), 0);
    chk(scl_drive_low == 1'b0 && sda_drive_low == 1'b0, "R1 lines",
        {30'd0, scl_drive_low, sda_drive_low}, 0);
    rst_n = 1'b1;

    // R2 single update, protocol shape R5, R6
    preset(24'h000000); clear_stats();
    pulse();
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R10 busy after pulse", 32'(busy), 1);
    wait_idle();
    chk(stored() == 24'h000001, "R2 count", 32'(stored()), 32'h1);
    chk(rd_ack == 2 && rd_nack == 1, "R5 ack,ack,nack", 32'(rd_ack * 16 + rd_nack), 32'h21);
    chk(n_a1 == 1, "R5 read control", 32'(n_a1), 1);
    chk(wr_cnt_last == 3 && wr_addr_last == 0, "R6 page write",
        32'(wr_cnt_last * 256 + wr_addr_last), 32'h300);
    chk(n_stop == 2, "R6 stops", 32'(n_stop), 2);
    chk(err == 1'b0, "R8 no error", 32'(err), 0);
    chk(scl_drive_low == 1'b0 && sda_drive_low == 1'b0, "R10 idle lines",
        {30'd0, scl_drive_low, sda_drive_low}, 0);

    // R4 busy polling right after a write
    clear_stats();
    pulse(); wait_idle();
    chk(poll_nacks > 0, "R4 polling", 32'(poll_nacks), 1);
    chk(stored() == 24'h000002, "R4 count after poll", 32'(stored()), 32'h2);

    // R3 carry corners
    carry_case(24'h0000FF);
    carry_case(24'h00FFFF);
    carry_case(24'hFFFFFF);

    // R7 queued pulses
    preset(24'h000010);
    for (int i = 0; i < 4; i++) pulse();
    wait_idle();
    chk(stored() == 24'h000014, "R7 queued four", 32'(stored()), 32'h14);

    // R7 saturation: 1 taken at once, 7 queued, rest dropped
    preset(24'h000100);
    for (int i = 0; i < 10; i++) pulse();
    wait_idle();
    chk(stored() == 24'h000108, "R7 saturation", 32'(stored()), 32'h108);

    // R8 NACK on first written byte
    preset(24'h0000FE); clear_stats();
    @(negedge clk); inj_req = 1'b1; @(negedge clk); inj_req = 1'b0;
    pulse(); wait_idle();
    chk(err == 1'b1, "R8 err set", 32'(err), 1);
    chk(stored() == 24'h0000FF, "R8 retry count", 32'(stored()), 32'hFF);
    chk(n_stop == 4, "R8 abort stop", 32'(n_stop), 4);
    pulse(); wait_idle();
    chk(err == 1'b0, "R8 err cleared", 32'(err), 0);
    chk(stored() == 24'h000100, "R8 next count", 32'(stored()), 32'h100);

    // random rounds (R2, R7)
    for (int r = 0; r < 6; r++) begin
      int n;
      v = 24'($urandom);
      n = 1 + int'($urandom % 4);
      preset(v);
      for (int k = 0; k < n; k++) begin
        pulse();
        repeat (int'($urandom % 200)) @(negedge clk);
      end
      wait_idle();
      chk(stored() == exp_count(v, n), "R2 random", 32'(stored()), 32'(exp_count(v, n)));
    end

    // R9 SCL high time
    chk(min_hi >= 2 * QTR, "R9 scl high time", 32'(min_hi), 32'(2 * QTR));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule